// File: doc/BRIEF.md
# Privilege Mode and Banked Stack Pointer Controller

This block keeps the execution context of a small processor core: whether the core runs ordinary thread code or an exception handler, and whether the running code is privileged or restricted to user level. It holds two 32-bit stack pointers, a main one and a process one, behind a single stack pointer alias. It also holds a two-bit control word. One control bit picks the process stack for thread code. The other drops thread code to user level. The core's pipeline raises exception entry and exception return pulses, writes the control word through a special-register write port, and reads and writes the stack pointer alias. The block returns the current mode, the privilege flag and two permission flags. One permission flag gates special-register move instructions and the other gates access to the system control space.

The mode is held by a two-state machine. `MODE_THREAD` is the reset state. An accepted exception entry takes it to `MODE_HANDLER` (transition "enter"). An accepted exception return takes it back to the mode saved at the matching entry (transition "return"). That mode is `MODE_HANDLER` for a nested handler and `MODE_THREAD` for the outermost one. All other cycles hold the state. Saved modes sit in a nest stack of parameterised depth. An entry when the stack is full, or a return while already in thread mode, is dropped and reported with a one-cycle error pulse. A control write that the privilege rules refuse, in whole or in part, gives a one-cycle "write ignored" pulse.

Top module: `priv_sp_ctrl`

## Requirements
- R1: The two stack pointers are separate registers. `sp_rd` shows only the selected one, and a `sp_wr_en` write changes only the selected one. The process pointer is selected when, and only when, `psp_active` is 1.
- R2: After reset the block is in thread mode and privileged, `ctl_rd` is 2'b00, the main pointer is selected, `sp_rd` equals `MAIN_SP_INIT` with bits [1:0] cleared, and `wr_ignored` and `nest_err` are 0.
- R3: Bits [1:0] of `sp_rd` are always 0. Bits [1:0] of written data are discarded.
- R4: Control bit 1 set in thread mode selects the process pointer. In handler mode `ctl_rd[1]` reads 0 and the main pointer is selected, while the stored bit is kept for the return to thread mode.
- R5: A control write sets bit 1 only in thread mode at privileged level. In handler mode the bit 1 field of the write is discarded.
- R6: Control bit 0 = 1 puts thread code at user level (`privileged` = 0). A control write at user level is discarded as a whole. In handler mode bit 0 is written.
- R7: An exception entry gives handler mode at privileged level on the next cycle. An exception return gives back the mode held before the matching entry. When entry and return arrive in the same cycle, the entry is taken and the return is dropped.
- R8: `sysreg_ok` and `scs_ok` are 1 when privileged and 0 at user level.
- R9: Thread code at user level cannot clear control bit 0. A handler can clear it, and thread code is then privileged after the return.
- R10: The nest stack holds `NEST_DEPTH` saved modes. An entry with the stack full, or a return in thread mode with nothing saved, changes no state and makes `nest_err` 1 for exactly the next cycle.
- R11: `wr_ignored` is 1 for exactly the cycle after a control write that is refused. A write is refused when it arrives at user level, or when it arrives in handler mode with data bit 1 different from the stored bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_enter | input | 1 | Exception entry pulse |
| exc_return | input | 1 | Exception return pulse |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 2 | Control word write data: bit 0 user level, bit 1 process stack select |
| sp_wr_en | input | 1 | Stack pointer alias write strobe |
| sp_wr_data | input | SP_W | Stack pointer alias write data |
| in_handler | output | 1 | 1 in handler mode, 0 in thread mode |
| privileged | output | 1 | 1 when the running code is privileged |
| ctl_rd | output | 2 | Control word as read by software |
| sp_rd | output | SP_W | Value of the stack pointer alias |
| psp_active | output | 1 | 1 when the process pointer is the selected bank |
| sysreg_ok | output | 1 | Special-register move instructions permitted |
| scs_ok | output | 1 | System control space access permitted |
| wr_ignored | output | 1 | One-cycle pulse after a refused control write |
| nest_err | output | 1 | One-cycle pulse after a nest overflow or underflow |

## Verification
Most wrong internal state shows at the ports right after the edge that creates it. A wrongly kept control bit changes `ctl_rd`, `privileged` or `psp_active` at once. A write that lands in the wrong bank shows on `sp_rd` as soon as that bank is selected again. A wrong saved mode or nest count can stay hidden through many cycles of handler work. It only shows at the return that should reach thread mode, or at the entry that should overflow. The bench therefore runs long random runs of nested entries and returns alongside directed walks to the full and empty depths.

// File: rtl/pmsp_pkg.sv
package pmsp_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    localparam int CTL_W       = 2;
    localparam int CTL_USER    = 0;
    localparam int CTL_PSP_SEL = 1;

endpackage

// File: rtl/pmsp_nest.sv
module pmsp_nest
    import pmsp_pkg::*;
#(
    parameter int NEST_DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enter_i,
    input  logic  return_i,
    input  mode_e mode_i,
    output logic  push_o,
    output logic  pop_o,
    output mode_e ret_mode_o,
    output logic  err_o
);

    localparam int CW = $clog2(NEST_DEPTH + 1);
    localparam int AW = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(NEST_DEPTH);

    logic [CW-1:0] cnt_q;
    mode_e         frame_q [NEST_DEPTH];
    logic          err_q;
    logic          full;
    logic          empty;
    logic [AW-1:0] top_idx;
    logic [AW-1:0] push_idx;

    always_comb begin
        full       = (cnt_q == FULL);
        empty      = (cnt_q == '0);
        push_o     = enter_i && !full;
        pop_o      = return_i && !enter_i && !empty;
        top_idx    = AW'(cnt_q - 1'b1);
        push_idx   = AW'(cnt_q);
        ret_mode_o = empty ? MODE_THREAD : frame_q[top_idx];
        err_o      = err_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
            for (int i = 0; i < NEST_DEPTH; i++) begin
                frame_q[i] <= MODE_THREAD;
            end
        end else begin
            err_q <= (enter_i && full) || (return_i && !enter_i && empty);
            if (push_o) begin
                frame_q[push_idx] <= mode_i;
                cnt_q             <= cnt_q + 1'b1;
            end else if (pop_o) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R10
    nest_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && full) |=> (cnt_q == FULL));

    // R10
    nest_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (return_i && !enter_i && empty) |=> (cnt_q == '0));

    // R10
    nest_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

endmodule

// File: rtl/pmsp_mode_fsm.sv
module pmsp_mode_fsm
    import pmsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  logic  pop_i,
    input  mode_e ret_mode_i,
    output mode_e mode_o,
    output logic  handler_o
);

    mode_e state_q;
    mode_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_THREAD: begin
                if (push_i) begin
                    state_d = MODE_HANDLER;
                end
            end
            MODE_HANDLER: begin
                if (push_i) begin
                    state_d = MODE_HANDLER;
                end else if (pop_i) begin
                    state_d = ret_mode_i;
                end
            end
            default: state_d = MODE_THREAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_THREAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mode_o    = state_q;
        handler_o = (state_q == MODE_HANDLER);
    end

    // R7
    enter_to_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (state_q == MODE_HANDLER));

    // R7
    thread_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MODE_THREAD) && !push_i) |=> (state_q == MODE_THREAD));

endmodule

// File: rtl/pmsp_ctrl_reg.sv
module pmsp_ctrl_reg
    import pmsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             handler_i,
    input  logic             wr_en_i,
    input  logic [CTL_W-1:0] wr_data_i,
    output logic [CTL_W-1:0] ctl_view_o,
    output logic             priv_o,
    output logic             psp_sel_o,
    output logic             ignored_o
);

    logic [CTL_W-1:0] ctl_q;
    logic [CTL_W-1:0] ctl_d;
    logic             ign_q;
    logic             refuse;
    logic             at_user;

    always_comb begin
        at_user = !handler_i && ctl_q[CTL_USER];
        ctl_d   = ctl_q;
        refuse  = 1'b0;
        if (wr_en_i) begin
            if (at_user) begin
                refuse = 1'b1;
            end else if (handler_i) begin
                ctl_d[CTL_USER] = wr_data_i[CTL_USER];
                refuse = (wr_data_i[CTL_PSP_SEL] != ctl_q[CTL_PSP_SEL]);
            end else begin
                ctl_d = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ign_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            ign_q <= refuse;
        end
    end

    always_comb begin
        priv_o                  = handler_i || !ctl_q[CTL_USER];
        psp_sel_o               = !handler_i && ctl_q[CTL_PSP_SEL];
        ctl_view_o[CTL_USER]    = ctl_q[CTL_USER];
        ctl_view_o[CTL_PSP_SEL] = handler_i ? 1'b0 : ctl_q[CTL_PSP_SEL];
        ignored_o               = ign_q;
    end

    // R9
    user_cannot_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CTL_USER] && !handler_i) |=> ctl_q[CTL_USER]);

    // R5
    handler_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handler_i |=> $stable(ctl_q[CTL_PSP_SEL]));

endmodule

// File: rtl/pmsp_sp_bank.sv
module pmsp_sp_bank #(
    parameter int          SP_W       = 32,
    parameter int          ALIGN_BITS = 2,
    parameter logic [SP_W-1:0] MAIN_INIT = '0,
    parameter logic [SP_W-1:0] PROC_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            psp_sel_i,
    input  logic            wr_en_i,
    input  logic [SP_W-1:0] wr_data_i,
    output logic [SP_W-1:0] sp_o
);

    localparam int NBANK = 2;
    localparam logic [SP_W-1:0] KEEP_MASK = ~((SP_W)'((1 << ALIGN_BITS) - 1));

    logic [SP_W-1:0] bank_val [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : gen_bank
        localparam logic [SP_W-1:0] INIT = (b == 0) ? MAIN_INIT : PROC_INIT;
        logic [SP_W-1:0] q;
        logic            sel;

        assign sel = (b == 0) ? !psp_sel_i : psp_sel_i;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= INIT & KEEP_MASK;
            end else if (wr_en_i && sel) begin
                q <= wr_data_i & KEEP_MASK;
            end
        end

        assign bank_val[b] = q;
    end

    assign sp_o = psp_sel_i ? bank_val[1] : bank_val[0];

    // R1
    proc_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !psp_sel_i) |=> $stable(bank_val[1]));

    // R1
    main_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && psp_sel_i) |=> $stable(bank_val[0]));

    // R3
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/priv_sp_ctrl.sv
module priv_sp_ctrl
    import pmsp_pkg::*;
#(
    parameter int              SP_W         = 32,
    parameter int              NEST_DEPTH   = 8,
    parameter logic [SP_W-1:0] MAIN_SP_INIT = 32'h2000_8000,
    parameter logic [SP_W-1:0] PROC_SP_INIT = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_enter,
    input  logic            exc_return,
    input  logic            ctl_wr_en,
    input  logic [1:0]      ctl_wr_data,
    input  logic            sp_wr_en,
    input  logic [SP_W-1:0] sp_wr_data,
    output logic            in_handler,
    output logic            privileged,
    output logic [1:0]      ctl_rd,
    output logic [SP_W-1:0] sp_rd,
    output logic            psp_active,
    output logic            sysreg_ok,
    output logic            scs_ok,
    output logic            wr_ignored,
    output logic            nest_err
);

    mode_e cur_mode;
    mode_e ret_mode;
    logic  push;
    logic  pop;
    logic  handler;
    logic  priv;
    logic  psp_sel;

    pmsp_nest #(
        .NEST_DEPTH (NEST_DEPTH)
    ) u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_i    (exc_enter),
        .return_i   (exc_return),
        .mode_i     (cur_mode),
        .push_o     (push),
        .pop_o      (pop),
        .ret_mode_o (ret_mode),
        .err_o      (nest_err)
    );

    pmsp_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .ret_mode_i (ret_mode),
        .mode_o     (cur_mode),
        .handler_o  (handler)
    );

    pmsp_ctrl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .handler_i  (handler),
        .wr_en_i    (ctl_wr_en),
        .wr_data_i  (ctl_wr_data),
        .ctl_view_o (ctl_rd),
        .priv_o     (priv),
        .psp_sel_o  (psp_sel),
        .ignored_o  (wr_ignored)
    );

    pmsp_sp_bank #(
        .SP_W       (SP_W),
        .ALIGN_BITS (2),
        .MAIN_INIT  (MAIN_SP_INIT),
        .PROC_INIT  (PROC_SP_INIT)
    ) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .psp_sel_i  (psp_sel),
        .wr_en_i    (sp_wr_en),
        .wr_data_i  (sp_wr_data),
        .sp_o       (sp_rd)
    );

    always_comb begin
        in_handler = handler;
        privileged = priv;
        psp_active = psp_sel;
        sysreg_ok  = priv;
        scs_ok     = priv;
    end

    // R4
    handler_main_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (!psp_active && (ctl_rd[1] == 1'b0)));

    // R7
    handler_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> privileged);

endmodule

// File: tb/priv_sp_ctrl_test.sv
`timescale 1ns/1ps
module priv_sp_ctrl_test;

    localparam int          SP_W  = 32;
    localparam int          DEPTH = 8;
    localparam logic [31:0] MINIT = 32'h2000_8000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            exc_enter = 1'b0;
    logic            exc_return = 1'b0;
    logic            ctl_wr_en = 1'b0;
    logic [1:0]      ctl_wr_data = 2'b00;
    logic            sp_wr_en = 1'b0;
    logic [SP_W-1:0] sp_wr_data = '0;
    logic            in_handler, privileged, psp_active, sysreg_ok, scs_ok;
    logic            wr_ignored, nest_err;
    logic [1:0]      ctl_rd;
    logic [SP_W-1:0] sp_rd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          m_depth;
    logic [1:0]  m_ctl;
    logic [31:0] m_msp, m_psp;
    logic        m_ign, m_err;

    always #2.5 clk = ~clk;

    priv_sp_ctrl #(
        .SP_W         (SP_W),
        .NEST_DEPTH   (DEPTH),
        .MAIN_SP_INIT (MINIT),
        .PROC_SP_INIT (32'h0)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_enter   (exc_enter),
        .exc_return  (exc_return),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .sp_wr_en    (sp_wr_en),
        .sp_wr_data  (sp_wr_data),
        .in_handler  (in_handler),
        .privileged  (privileged),
        .ctl_rd      (ctl_rd),
        .sp_rd       (sp_rd),
        .psp_active  (psp_active),
        .sysreg_ok   (sysreg_ok),
        .scs_ok      (scs_ok),
        .wr_ignored  (wr_ignored),
        .nest_err    (nest_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic e_handler();
        return m_depth > 0;
    endfunction

    function automatic logic e_priv();
        return e_handler() || !m_ctl[0];
    endfunction

    function automatic logic e_psp();
        return !e_handler() && m_ctl[1];
    endfunction

    task automatic check_all();
        chk("R7 in_handler", {31'b0, in_handler}, {31'b0, e_handler()});
        chk("R6 privileged", {31'b0, privileged}, {31'b0, e_priv()});
        chk("R4 ctl_rd", {30'b0, ctl_rd}, {30'b0, e_handler() ? 1'b0 : m_ctl[1], m_ctl[0]});
        chk("R4 psp_active", {31'b0, psp_active}, {31'b0, e_psp()});
        chk("R1 sp_rd", sp_rd, e_psp() ? m_psp : m_msp);
        chk("R3 sp_rd low bits", {30'b0, sp_rd[1:0]}, 32'h0);
        chk("R8 sysreg_ok", {31'b0, sysreg_ok}, {31'b0, e_priv()});
        chk("R8 scs_ok", {31'b0, scs_ok}, {31'b0, e_priv()});
        chk("R11 wr_ignored", {31'b0, wr_ignored}, {31'b0, m_ign});
        chk("R10 nest_err", {31'b0, nest_err}, {31'b0, m_err});
    endtask

    task automatic step(input logic en, input logic rt, input logic cwe, input logic [1:0] cwd,
                        input logic swe, input logic [31:0] swd);
        logic h, user;
        @(negedge clk);
        exc_enter   = en;
        exc_return  = rt;
        ctl_wr_en   = cwe;
        ctl_wr_data = cwd;
        sp_wr_en    = swe;
        sp_wr_data  = swd;
        h    = e_handler();
        user = !h && m_ctl[0];
        m_ign = cwe && (user || (h && (cwd[1] != m_ctl[1])));
        if (swe) begin
            if (!h && m_ctl[1]) m_psp = swd & 32'hFFFF_FFFC;
            else                m_msp = swd & 32'hFFFF_FFFC;
        end
        if (cwe && !user) begin
            if (h) m_ctl[0] = cwd[0];
            else   m_ctl = cwd;
        end
        m_err = 1'b0;
        if (en) begin
            if (m_depth == DEPTH) m_err = 1'b1;
            else                  m_depth++;
        end else if (rt) begin
            if (m_depth == 0) m_err = 1'b1;
            else              m_depth--;
        end
        @(posedge clk);
        #1;
        check_all();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        m_depth = 0; m_ctl = 2'b00; m_msp = MINIT & 32'hFFFF_FFFC; m_psp = 32'h0;
        m_ign = 1'b0; m_err = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("R2 in_handler", {31'b0, in_handler}, 32'h0);
        chk("R2 privileged", {31'b0, privileged}, 32'h1);
        chk("R2 ctl_rd", {30'b0, ctl_rd}, 32'h0);
        chk("R2 sp_rd", sp_rd, MINIT);
        chk("R2 psp_active", {31'b0, psp_active}, 32'h0);
        chk("R2 pulses", {30'b0, wr_ignored, nest_err}, 32'h0);

        // R3 unaligned write to main
        step(0, 0, 0, 2'b00, 1, 32'h0000_1003);
        // R1 select process, write it, then back to main
        step(0, 0, 1, 2'b10, 0, 0);
        step(0, 0, 0, 2'b00, 1, 32'h0000_2007);
        step(0, 0, 1, 2'b00, 0, 0);
        chk("R1 main kept", sp_rd, 32'h0000_1000);
        step(0, 0, 1, 2'b10, 0, 0);
        chk("R1 process kept", sp_rd, 32'h0000_2004);
        // R4 handler reads bit1 as 0 and uses main
        step(1, 0, 0, 2'b00, 0, 0);
        chk("R4 handler main", sp_rd, 32'h0000_1000);
        // R5 handler write with bit1 cleared is refused for bit1 (R11 pulse)
        step(0, 0, 1, 2'b01, 0, 0);
        step(0, 1, 0, 2'b00, 0, 0);
        chk("R5 bit1 kept", {30'b0, ctl_rd}, 32'h3);
        // R9 user cannot clear bit0
        step(0, 0, 1, 2'b00, 0, 0);
        chk("R9 user stays", {31'b0, privileged}, 32'h0);
        step(1, 0, 0, 2'b00, 0, 0);
        step(0, 0, 1, 2'b10, 0, 0);
        step(0, 1, 0, 2'b00, 0, 0);
        chk("R9 handler cleared", {31'b0, privileged}, 32'h1);
        // R7 enter and return together: enter wins
        step(1, 1, 0, 2'b00, 0, 0);
        chk("R7 enter wins", {31'b0, in_handler}, 32'h1);
        // R10 overflow then underflow
        for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0, 2'b00, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 0, 2'b00, 0, 0);
        step(0, 0, 0, 2'b00, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic r_en, r_rt, r_cwe, r_swe;
            r_en  = ($urandom % 6) == 0;
            r_rt  = ($urandom % 5) == 0;
            r_cwe = ($urandom % 3) == 0;
            r_swe = ($urandom % 3) == 0;
            step(r_en, r_rt, r_cwe, 2'($urandom), r_swe, $urandom);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule